// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Sequencer

This block keeps an asynchronous DRAM's contents alive and brings the device up after power-on. After reset it waits a programmable pause. It then runs a fixed number of initialization cycles, and every one of them is a CAS-before-RAS refresh. Once those are done it raises `ready_o` and starts an interval timer. The timer spaces refreshes so that every row is visited within the retention time.

Each refresh is requested from the access controller over a request/grant pair. Once the grant is high, the sequencer drives RAS_n, CAS_n and W_n itself. CAS falls before RAS. W is held high around the RAS edge, so the device never enters its parallel test mode. No address is needed, because the device picks the row from its own internal counter.

Refreshes the controller could not grant in time are queued up to a limit. They are then paid back in one burst. During the burst CAS stays low and only RAS toggles. A sticky flag reports a tick that found the queue already full.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, `ras_n_o`, `cas_n_o` and `w_n_o` are high and `req_o`, `drv_en_o`, `ready_o` and `ovf_o` are low.
- R2: `req_o` stays low for at least PAUSE_US microseconds (PAUSE_US*CLK_MHZ clock cycles) after reset release. The first request follows the pause within a few cycles.
- R3: After the pause exactly INIT_CYC refresh cycles are issued. `ready_o` rises only after the precharge of the last of them, and then stays high.
- R4: Every RAS falling edge finds CAS already low for at least T_CSR_NS. CAS stays low for the whole RAS low time, which is at least T_CHR_NS.
- R5: W_n is high for at least T_WSU_NS before each RAS falling edge and stays high while RAS is low.
- R6: RAS low lasts at least T_RAS_NS. The time RAS is high between two refreshes is at least T_RP_NS. Two RAS falling edges are at least T_RC_NS apart.
- R7: Once ready, one refresh is due every RETAIN_US*CLK_MHZ/ROWS cycles.
- R8: While `gnt_i` is low, `drv_en_o` is low and all three strobes are high.
- R9: `req_o` falls only after the precharge of the final cycle of a burst has completed, with RAS high for at least T_RP_NS.
- R10: Due refreshes that could not be granted are queued, up to PEND_MAX. When the grant arrives they are issued back to back, and CAS falls only once per burst.
- R11: A tick that arrives with PEND_MAX refreshes already queued sets `ovf_o`. The flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gnt_i | input | 1 | Grant from the access controller; must stay high until `req_o` falls |
| req_o | output | 1 | Request for ownership of the DRAM strobes |
| drv_en_o | output | 1 | High while the sequencer is driving the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| w_n_o | output | 1 | Write enable, held high (read) so no test mode is entered |
| ready_o | output | 1 | Pause and initialization complete |
| ovf_o | output | 1 | Sticky refresh backlog overflow |

## Verification
The bench builds the block with a 50 MHz clock, a 1 us pause (50 cycles), eight rows over 8 us and a queue limit of three. These values put the refresh interval at 50 cycles. With that interval, a whole initialization run, ten steady refresh periods, a two-deep backlog and a full overflow all fit within about a thousand cycles. The strobe timings are left at the -60 grade nanosecond values. At a 20 ns clock they round to the smallest legal cycle counts: one cycle of CAS lead and three cycles each of RAS low and precharge. Every edge-spacing limit is therefore tested at its tightest point.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_WSU,
      ST_CSR,
      ST_RAS,
      ST_RP
   } rfsh_st_e;

   // Round a nanosecond limit up to whole clock cycles, never below one.
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rfsh_timebase.sv
module rfsh_timebase #(
   parameter int PAUSE_CYC    = 10000,
   parameter int INTERVAL_CYC = 781
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic pause_done_o,
   output logic tick_o
);
   localparam int PCW = (PAUSE_CYC < 1) ? 1 : $clog2(PAUSE_CYC + 1);
   localparam int ICW = $clog2(INTERVAL_CYC);

   if (INTERVAL_CYC < 2) begin : g_bad_interval
      $error("INTERVAL_CYC must be at least 2");
   end

   // Power-up pause: either absent or a saturating up-counter.
   if (PAUSE_CYC == 0) begin : g_nopause
      assign pause_done_o = 1'b1;
   end else begin : g_pause
      logic [PCW-1:0] pcnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pcnt_q <= '0;
         end else if (pcnt_q != PCW'(PAUSE_CYC)) begin
            pcnt_q <= pcnt_q + PCW'(1);
         end
      end
      assign pause_done_o = (pcnt_q == PCW'(PAUSE_CYC));
   end

   // Refresh interval timer, held cleared until the block is ready.
   logic [ICW-1:0] icnt_q;
   logic           wrap;

   assign wrap   = (icnt_q == ICW'(INTERVAL_CYC - 1));
   assign tick_o = run_i && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         icnt_q <= '0;
      end else if (!run_i || wrap) begin
         icnt_q <= '0;
      end else begin
         icnt_q <= icnt_q + ICW'(1);
      end
   end

   // R2: no refresh is scheduled while the pause is running
   a_r2_no_tick_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
      !pause_done_o |-> !tick_o);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
   parameter int INIT_CYC = 8,
   parameter int PEND_MAX = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic tick_i,
   input  logic take_i,
   output logic need_o,
   output logic init_busy_o,
   output logic ovf_o
);
   localparam int IW = $clog2(INIT_CYC + 1);
   localparam int PW = $clog2(PEND_MAX + 1);

   if (INIT_CYC < 1) begin : g_bad_init
      $error("INIT_CYC must be at least 1");
   end
   if (PEND_MAX < 1) begin : g_bad_pend
      $error("PEND_MAX must be at least 1");
   end

   logic          loaded_q;
   logic [IW-1:0] init_left_q;
   logic [PW-1:0] pend_q, pend_nx;
   logic          ovf_q, ovf_set;
   logic          take_pend;

   // A refresh goes to the init budget first, then to the backlog.
   assign take_pend = take_i && loaded_q && (init_left_q == '0);

   always_comb begin
      pend_nx = pend_q;
      ovf_set = 1'b0;
      if (tick_i && !take_pend) begin
         if (pend_q == PW'(PEND_MAX)) ovf_set = 1'b1;
         else                         pend_nx = pend_q + PW'(1);
      end else if (!tick_i && take_pend && (pend_q != '0)) begin
         pend_nx = pend_q - PW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded_q    <= 1'b0;
         init_left_q <= '0;
         pend_q      <= '0;
         ovf_q       <= 1'b0;
      end else begin
         if (start_i && !loaded_q) begin
            loaded_q    <= 1'b1;
            init_left_q <= IW'(INIT_CYC);
         end else if (take_i && (init_left_q != '0)) begin
            init_left_q <= init_left_q - IW'(1);
         end
         pend_q <= pend_nx;
         if (ovf_set) ovf_q <= 1'b1;
      end
   end

   assign need_o      = (init_left_q != '0) || (pend_q != '0);
   assign init_busy_o = !loaded_q || (init_left_q != '0);
   assign ovf_o       = ovf_q;

   // R10: the strobe sequencer only starts a refresh that is owed
   a_r10_take_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> need_o);

   // R11: overflow stays set until reset
   a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

endmodule

// File: rtl/rfsh_strobe_fsm.sv
module rfsh_strobe_fsm
   import rfsh_pkg::*;
#(
   parameter int WSU_CYC = 1,
   parameter int CSR_CYC = 1,
   parameter int RAS_CYC = 3,
   parameter int RP_CYC  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic need_i,
   input  logic gnt_i,
   output logic take_o,
   output logic req_o,
   output logic drv_en_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic w_n_o,
   output logic idle_o
);
   localparam int LMAX = imax(imax(WSU_CYC, CSR_CYC), imax(RAS_CYC, RP_CYC));
   localparam int CW   = $clog2(LMAX + 1);
   localparam logic [CW-1:0] L_WSU = CW'(WSU_CYC - 1);
   localparam logic [CW-1:0] L_CSR = CW'(CSR_CYC - 1);
   localparam logic [CW-1:0] L_RAS = CW'(RAS_CYC - 1);
   localparam logic [CW-1:0] L_RP  = CW'(RP_CYC - 1);

   rfsh_st_e      st_q;
   logic [CW-1:0] cnt_q;
   logic          more_q;   // another refresh follows, keep CAS low in precharge
   logic          last;
   logic          busy;

   assign last = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         more_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (need_i) st_q <= ST_WAIT;
            ST_WAIT: if (gnt_i) begin
               st_q  <= ST_WSU;
               cnt_q <= L_WSU;
            end
            ST_WSU: begin
               if (!gnt_i)    st_q <= ST_WAIT;
               else if (last) begin
                  st_q  <= ST_CSR;
                  cnt_q <= L_CSR;
               end else       cnt_q <= cnt_q - CW'(1);
            end
            ST_CSR: begin
               if (!gnt_i)    st_q <= ST_WAIT;
               else if (last) begin
                  st_q  <= ST_RAS;
                  cnt_q <= L_RAS;
               end else       cnt_q <= cnt_q - CW'(1);
            end
            ST_RAS: begin
               if (last) begin
                  st_q   <= ST_RP;
                  cnt_q  <= L_RP;
                  more_q <= need_i;
               end else cnt_q <= cnt_q - CW'(1);
            end
            ST_RP: begin
               if (last) begin
                  if (more_q) begin
                     st_q  <= ST_RAS;
                     cnt_q <= L_RAS;
                  end else if (need_i) begin
                     st_q  <= ST_CSR;
                     cnt_q <= L_CSR;
                  end else begin
                     st_q  <= ST_IDLE;
                  end
                  more_q <= 1'b0;
               end else cnt_q <= cnt_q - CW'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // A refresh is counted at the RAS falling edge it produces.
   assign take_o = ((st_q == ST_CSR) && gnt_i && last) ||
                   ((st_q == ST_RP) && last && more_q);

   assign busy     = (st_q == ST_WSU) || (st_q == ST_CSR) ||
                     (st_q == ST_RAS) || (st_q == ST_RP);
   assign drv_en_o = busy && gnt_i;
   assign req_o    = (st_q != ST_IDLE);
   assign idle_o   = (st_q == ST_IDLE);
   assign ras_n_o  = !(drv_en_o && (st_q == ST_RAS));
   assign cas_n_o  = !(drv_en_o && ((st_q == ST_CSR) || (st_q == ST_RAS) ||
                                    ((st_q == ST_RP) && more_q)));
   // Read level throughout; a low level at the RAS edge would select test mode.
   assign w_n_o    = 1'b1;

   // R4: CAS is already low when RAS falls
   a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o) |-> $past(!cas_n_o));

   // R9: request drops only with RAS precharged
   a_r9_req_after_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_o) |-> (ras_n_o && $past(ras_n_o)));

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
   import rfsh_pkg::*;
#(
   parameter int CLK_MHZ   = 50,
   parameter int PAUSE_US  = 200,
   parameter int INIT_CYC  = 8,
   parameter int ROWS      = 4096,
   parameter int RETAIN_US = 64000,
   parameter int PEND_MAX  = 8,
   parameter int T_CSR_NS  = 5,
   parameter int T_CHR_NS  = 10,
   parameter int T_WSU_NS  = 10,
   parameter int T_RAS_NS  = 60,
   parameter int T_RP_NS   = 40,
   parameter int T_RC_NS   = 104
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gnt_i,
   output logic req_o,
   output logic drv_en_o,
   output logic ras_n_o,
   output logic cas_n_o,
   output logic w_n_o,
   output logic ready_o,
   output logic ovf_o
);
   localparam int CLK_NS       = 1000 / CLK_MHZ;
   localparam int PAUSE_CYC    = PAUSE_US * CLK_MHZ;
   localparam int INTERVAL_CYC = (RETAIN_US * CLK_MHZ) / ROWS;
   localparam int CSR_CYC      = ns_to_cyc(T_CSR_NS, CLK_NS);
   localparam int WSU_CYC      = ns_to_cyc(T_WSU_NS, CLK_NS);
   localparam int RAS_CYC      = imax(ns_to_cyc(T_RAS_NS, CLK_NS), ns_to_cyc(T_CHR_NS, CLK_NS));
   localparam int RP_CYC       = imax(ns_to_cyc(T_RP_NS, CLK_NS),
                                      ns_to_cyc(T_RC_NS, CLK_NS) - RAS_CYC);
   localparam int CYCLE_LEN    = WSU_CYC + CSR_CYC + RAS_CYC + RP_CYC + 2;
   localparam int RW           = $clog2(RAS_CYC + 2);

   if (CLK_MHZ < 1 || CLK_MHZ > 1000) begin : g_bad_clk
      $error("CLK_MHZ out of range");
   end
   if (INTERVAL_CYC <= CYCLE_LEN) begin : g_bad_rate
      $error("refresh interval shorter than one refresh cycle");
   end

   logic pause_done, tick, need, take, init_busy, fsm_idle;
   logic ready_q;

   rfsh_timebase #(
      .PAUSE_CYC    (PAUSE_CYC),
      .INTERVAL_CYC (INTERVAL_CYC)
   ) timebase_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (ready_q),
      .pause_done_o (pause_done),
      .tick_o       (tick)
   );

   rfsh_backlog #(
      .INIT_CYC (INIT_CYC),
      .PEND_MAX (PEND_MAX)
   ) backlog_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (pause_done),
      .tick_i      (tick),
      .take_i      (take),
      .need_o      (need),
      .init_busy_o (init_busy),
      .ovf_o       (ovf_o)
   );

   rfsh_strobe_fsm #(
      .WSU_CYC (WSU_CYC),
      .CSR_CYC (CSR_CYC),
      .RAS_CYC (RAS_CYC),
      .RP_CYC  (RP_CYC)
   ) strobe_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .need_i   (need),
      .gnt_i    (gnt_i),
      .take_o   (take),
      .req_o    (req_o),
      .drv_en_o (drv_en_o),
      .ras_n_o  (ras_n_o),
      .cas_n_o  (cas_n_o),
      .w_n_o    (w_n_o),
      .idle_o   (fsm_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ready_q <= 1'b0;
      else if (!init_busy && fsm_idle) ready_q <= 1'b1;
   end
   assign ready_o = ready_q;

   // Length of the current RAS low pulse, used by the width check below.
   logic [RW-1:0] ras_lo_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ras_lo_run_q <= '0;
      else if (ras_n_o)                        ras_lo_run_q <= '0;
      else if (ras_lo_run_q != RW'(RAS_CYC + 1)) ras_lo_run_q <= ras_lo_run_q + RW'(1);
   end

   // R3: ready only once the init budget is spent and the strobes are idle
   a_r3_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> (!init_busy && !req_o));

   // R6: RAS low pulse lasts its full width
   a_r6_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ras_n_o) && gnt_i) |-> (ras_lo_run_q >= RW'(RAS_CYC)));

   // R8: strobes released without a grant
   a_r8_quiet_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_i |-> (ras_n_o && cas_n_o && !drv_en_o));

   // R5: write enable high whenever RAS is low
   a_r5_w_high_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n_o |-> w_n_o);

endmodule

// File: tb/dram_rfsh_seq_tb_top.sv
module dram_rfsh_seq_tb_top;
   localparam int CLK_NS   = 20;
   localparam int PAUSE_CY = 50;    // 1 us at 50 MHz
   localparam int IV       = 50;    // 8 us / 8 rows at 50 MHz
   localparam int NINIT    = 8;
   localparam int PMAX     = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gnt = 1'b0;
   logic req, drv, ras_n, cas_n, w_n, ready, ovf;

   always #10 clk = ~clk;

   dram_rfsh_seq #(
      .CLK_MHZ   (50),
      .PAUSE_US  (1),
      .INIT_CYC  (NINIT),
      .ROWS      (8),
      .RETAIN_US (8),
      .PEND_MAX  (PMAX)
   ) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .gnt_i    (gnt),
      .req_o    (req),
      .drv_en_o (drv),
      .ras_n_o  (ras_n),
      .cas_n_o  (cas_n),
      .w_n_o    (w_n),
      .ready_o  (ready),
      .ovf_o    (ovf)
   );

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   // Strobe monitor, sampled away from the rising edge.
   int rfsh_cnt = 0, cas_fall_cnt = 0, nogrant_viol = 0;
   int cas_lo_run = 0, w_hi_run = 0, ras_lo_run = 0, ras_hi_run = 0, since_fall = 0;
   bit seen_fall = 0, cas_hold_ok = 1, w_hold_ok = 1;
   logic p_ras = 1'b1, p_cas = 1'b1, p_req = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (!done && cyc > 20000) begin
         done = 1'b1;
         chk(1'b0, "watchdog", cyc, 20000);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
      if (rst_n) begin
         if (p_ras && !ras_n) begin
            rfsh_cnt++;
            chk(cas_lo_run * CLK_NS >= 5, "R4 CAS lead before RAS", cas_lo_run, 1);
            chk(w_hi_run * CLK_NS >= 10, "R5 W setup before RAS", w_hi_run, 1);
            chk(ras_hi_run * CLK_NS >= 40, "R6 precharge", ras_hi_run, 2);
            if (seen_fall) chk(since_fall * CLK_NS >= 104, "R6 cycle time", since_fall, 6);
            seen_fall = 1; since_fall = 0;
            cas_hold_ok = 1; w_hold_ok = 1;
         end
         if (!ras_n) begin
            if (cas_n) cas_hold_ok = 0;
            if (!w_n)  w_hold_ok = 0;
         end
         if (!p_ras && ras_n) begin
            chk(ras_lo_run * CLK_NS >= 60, "R6 RAS width", ras_lo_run, 3);
            chk(cas_hold_ok, "R4 CAS held through RAS low", cas_hold_ok, 1);
            chk(w_hold_ok, "R5 W held through RAS low", w_hold_ok, 1);
         end
         if (p_cas && !cas_n) cas_fall_cnt++;
         if (p_req && !req)
            chk(ras_n && ras_hi_run * CLK_NS >= 40, "R9 release after precharge", ras_hi_run, 2);
         if (!gnt && (!ras_n || !cas_n || drv)) nogrant_viol++;
         cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
         w_hi_run   = w_n ? w_hi_run + 1 : 0;
         ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
         ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
         since_fall++;
      end
      p_ras = ras_n; p_cas = cas_n; p_req = req;
   end

   task automatic wait_cond_req(input bit lvl, input int limit, output int n);
      n = 0;
      while (req !== lvl && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk(ras_n && cas_n && w_n, "R1 strobes high in reset", {ras_n, cas_n, w_n}, 7);
      chk(!req && !drv && !ready && !ovf, "R1 flags low in reset", {req, drv, ready, ovf}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ras_n && cas_n && !req && !ready && !ovf, "R1 state after release",
          {ras_n, cas_n, req, ready, ovf}, 24);
   endtask

   task automatic t_pause_init;
      int n;
      gnt = 1'b1;
      rfsh_cnt = 0;
      wait_cond_req(1'b1, 200, n);
      n = n + 1;   // one negedge already elapsed in t_reset
      chk(n >= PAUSE_CY, "R2 no request during pause", n, PAUSE_CY);
      chk(n <= PAUSE_CY + 5, "R2 request follows pause", n, PAUSE_CY);
      chk(!ready, "R3 not ready during init", ready, 0);
      n = 0;
      while (!ready && n < 300) begin
         @(negedge clk);
         n++;
         if (!ready && rfsh_cnt == NINIT && !req) ;
      end
      chk(ready, "R3 ready reached", ready, 1);
      chk(rfsh_cnt == NINIT, "R3 init refresh count", rfsh_cnt, NINIT);
      chk(!req && ras_n, "R3 ready after last precharge", req, 0);
      chk(!ovf, "R11 no overflow after init", ovf, 0);
   endtask

   task automatic t_steady;
      rfsh_cnt = 0;
      repeat (10 * IV) @(negedge clk);
      chk(rfsh_cnt >= 9 && rfsh_cnt <= 11, "R7 refresh rate", rfsh_cnt, 10);
      chk(w_n, "R5 W stays high", w_n, 1);
   endtask

   task automatic t_backlog;
      int n, base_r, base_c;
      wait_cond_req(1'b0, 100, n);
      gnt = 1'b0;
      wait_cond_req(1'b1, 2 * IV, n);
      chk(req, "R9 request raised without grant", req, 1);
      base_r = rfsh_cnt;
      repeat (IV + 10) @(negedge clk);
      chk(rfsh_cnt == base_r, "R8 no refresh without grant", rfsh_cnt - base_r, 0);
      chk(req && !drv, "R8 waiting with strobes released", drv, 0);
      base_r = rfsh_cnt;
      base_c = cas_fall_cnt;
      gnt = 1'b1;
      @(negedge clk);
      wait_cond_req(1'b0, 100, n);
      chk(rfsh_cnt - base_r == 2, "R10 backlog of two paid back", rfsh_cnt - base_r, 2);
      chk(cas_fall_cnt - base_c == 1, "R10 CAS held low across burst", cas_fall_cnt - base_c, 1);
      chk(!ovf, "R11 no overflow below limit", ovf, 0);
   endtask

   task automatic t_overflow;
      int n, base_r;
      wait_cond_req(1'b0, 100, n);
      gnt = 1'b0;
      wait_cond_req(1'b1, 2 * IV, n);
      repeat (2 * IV + 10) @(negedge clk);
      chk(!ovf, "R11 queue full but not overflowed", ovf, 0);
      repeat (IV) @(negedge clk);
      chk(ovf, "R11 overflow on tick with full queue", ovf, 1);
      base_r = rfsh_cnt;
      gnt = 1'b1;
      @(negedge clk);
      wait_cond_req(1'b0, 100, n);
      chk(rfsh_cnt - base_r == PMAX, "R10 burst limited to queue depth", rfsh_cnt - base_r, PMAX);
      chk(ovf, "R11 overflow sticky", ovf, 1);
      chk(ready, "R3 ready stays high", ready, 1);
      chk(nogrant_viol == 0, "R8 strobes quiet whenever grant low", nogrant_viol, 0);
   endtask

   initial begin
      t_reset;
      t_pause_init;
      t_steady;
      t_backlog;
      t_overflow;
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule